// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting channel of a three-channel interval timer. A host programs it over a byte-wide bus using three strobes: one for control words, one for count bytes and one for count reads. A control word carries a channel address. The channel accepts only words that carry its own address and ignores the rest. An accepted word sets how count bytes are transferred and how the output line behaves.

The count is loaded one byte at a time and reads back one byte at a time. A latch command takes a snapshot of the running count, so that software can read a consistent value while counting goes on. Counting advances on a count-enable tick input. Three output behaviours are supported: terminal-count interrupt, rate generator and square wave. Counting is always binary. A loaded value of zero stands for 65536.

Top module: `pit_channel`

## Requirements
- R1: After reset the output line is low, the access mode is low-then-high, and two reads return 0x00 and 0x00.
- R2: A control word is decoded as follows: bits 7:6 give the channel address, bits 5:4 give the access mode (0 latch, 1 low byte only, 2 high byte only, 3 low then high), bits 3:1 give the mode, and bit 0 is the BCD select, which has no effect. A word whose address differs from the `CH_ID` parameter is ignored. This includes address 3.
- R3: A latch command copies the running count without stopping it. A further latch command is ignored while an earlier snapshot is still unread.
- R4: While a snapshot is pending, reads return the snapshot. It is released after its last byte has been read: the single byte in a one-byte access mode, or the high byte in low-then-high mode. Later reads return the live count.
- R5: In low-then-high mode, writes take the low byte first and then the high byte, and reads return the low byte first and then the high byte. A non-latch control word returns both byte pointers to the low byte and drops any pending snapshot.
- R6: Low-only access loads {0x00, byte} and reads the low byte. High-only access loads {byte, 0x00} and reads the high byte.
- R7: Mode 0 (interrupt on terminal count): programming or completing a count load drives the output low. Each tick decrements the count. The output goes high on the tick that brings the count to zero and stays high until the channel is reprogrammed or reloaded.
- R8: Mode 2 (rate generator): programming drives the output high. The output goes low for one tick period when the count reaches 1. On the next tick the count reloads from the period and the output returns high.
- R9: Mode 3 (square wave): programming drives the output high. The count decrements by 2 from the period with bit 0 cleared. When the count reaches zero the output toggles and the count reloads, so the output toggles every floor(N/2) ticks.
- R10: A loaded count of 0 stands for 65536 ticks.
- R11: Ticks are ignored after a non-latch control word until a full count has been loaded. They are also ignored after the first byte of a low-then-high load, until the high byte arrives. A count load in the same cycle as a tick takes priority over the tick.
- R12: Mode values 6 and 7 behave as 2 and 3. Values 1, 4 and 5 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control-word write strobe |
| dataWr | input | 1 | Count-byte write strobe |
| dataRd | input | 1 | Count-byte read strobe |
| wrData | input | BYTE_W | Write data byte |
| cntTick | input | 1 | Count-enable tick |
| rdData | output | BYTE_W | Read data byte, valid while dataRd is high |
| outLine | output | 1 | Timer output line |

## Verification
The bench builds the channel with `CH_ID` set to 1 and the default byte width of 8. Because the channel address is not zero, control words for channel 0 and for address 3 reach a channel that must ignore them, so the ignore path is exercised. The default width makes a loaded zero cost 65536 ticks, which is short enough to run in full. The 65536 case can therefore be checked right up to the tick where the output rises.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } accMode_t;

  typedef enum logic [1:0] {
    OP_TERM   = 2'd0,
    OP_RATE   = 2'd1,
    OP_SQUARE = 2'd2
  } opMode_t;

  // Strobes and selects passed from control to datapath
  typedef struct packed {
    logic     prog;        // accepted non-latch control word
    opMode_t  progMode;    // mode carried by that word
    logic     stageLo;     // hold first byte of a two-byte load
    logic     commit;      // full count available this cycle
    accMode_t commitSel;   // how to assemble the count
    logic     capLatch;    // take a count snapshot
    logic     rdFromLatch; // read source is the snapshot
    logic     rdHigh;      // read returns upper byte
  } ctrlStrobe_t;

  function automatic opMode_t decodeMode(input logic [2:0] m);
    case (m)
      3'd2, 3'd6: decodeMode = OP_RATE;
      3'd3, 3'd7: decodeMode = OP_SQUARE;
      default:    decodeMode = OP_TERM;
    endcase
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CH_ID  = 0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [BYTE_W-1:0] wrData,
  output ctrlStrobe_t       strb,
  output opMode_t           curMode
);

  localparam logic [1:0] SEL_ID = 2'(CH_ID);

  accMode_t accMode;
  opMode_t  opMode;
  logic     rdPtrHi, wrPtrHi, latchPend;

  logic [1:0] selF, rwF;
  logic [2:0] modeF;
  logic       addrHit, isLatchCmd, isProg, wrEn, rdEn, release_;

  assign selF  = wrData[BYTE_W-1:BYTE_W-2];
  assign rwF   = wrData[BYTE_W-3:BYTE_W-4];
  assign modeF = wrData[3:1];

  assign addrHit    = ctrlWr && (selF == SEL_ID);
  assign isLatchCmd = addrHit && (rwF == ACC_LATCH);
  assign isProg     = addrHit && (rwF != ACC_LATCH);
  assign wrEn       = dataWr && !ctrlWr;
  assign rdEn       = dataRd && !ctrlWr;
  assign release_   = rdEn && latchPend && ((accMode != ACC_BOTH) || rdPtrHi);
  assign curMode    = opMode;

  always_comb begin
    strb             = '0;
    strb.prog        = isProg;
    strb.progMode    = decodeMode(modeF);
    strb.capLatch    = isLatchCmd && !latchPend;
    strb.commitSel   = accMode;
    strb.rdFromLatch = latchPend;
    strb.rdHigh      = (accMode == ACC_HI) || ((accMode == ACC_BOTH) && rdPtrHi);
    if (wrEn) begin
      if (accMode == ACC_BOTH && !wrPtrHi) strb.stageLo = 1'b1;
      else                                 strb.commit  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode   <= ACC_BOTH;
      opMode    <= OP_TERM;
      rdPtrHi   <= 1'b0;
      wrPtrHi   <= 1'b0;
      latchPend <= 1'b0;
    end else if (isProg) begin
      accMode   <= accMode_t'(rwF);
      opMode    <= decodeMode(modeF);
      rdPtrHi   <= 1'b0;
      wrPtrHi   <= 1'b0;
      latchPend <= 1'b0;
    end else begin
      if (isLatchCmd) latchPend <= 1'b1;
      if (wrEn && accMode == ACC_BOTH) wrPtrHi <= ~wrPtrHi;
      if (rdEn && accMode == ACC_BOTH) rdPtrHi <= ~rdPtrHi;
      if (release_) latchPend <= 1'b0;
    end
  end

  AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rstN)
    isProg |=> (!rdPtrHi && !wrPtrHi && !latchPend)); // R5
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (latchPend && isLatchCmd) |=> latchPend); // R3
  AST_LATCH_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (latchPend && rdEn && accMode != ACC_BOTH) |=> !latchPend); // R4

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  opMode_t           curMode,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              cntTick,
  output logic [BYTE_W-1:0] rdData,
  output logic              outLine
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  count, period, latchVal, loadVal, rdSrc;
  logic [CNT_W-1:0]  evenLoad, evenPeriod;
  logic [BYTE_W-1:0] stageLo;
  logic              armed, outR;

  always_comb begin
    case (strb.commitSel)
      ACC_LO:  loadVal = {{BYTE_W{1'b0}}, wrData};
      ACC_HI:  loadVal = {wrData, {BYTE_W{1'b0}}};
      default: loadVal = {wrData, stageLo};
    endcase
  end

  assign evenLoad   = {loadVal[CNT_W-1:1], 1'b0};
  assign evenPeriod = {period[CNT_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      period   <= '0;
      latchVal <= '0;
      stageLo  <= '0;
      armed    <= 1'b0;
      outR     <= 1'b0;
    end else begin
      if (strb.capLatch) latchVal <= count;
      if (strb.stageLo) begin
        stageLo <= wrData;
        armed   <= 1'b0;
      end
      if (strb.prog) begin
        armed <= 1'b0;
        outR  <= (strb.progMode != OP_TERM);
      end else if (strb.commit) begin
        period <= loadVal;
        count  <= (curMode == OP_SQUARE) ? evenLoad : loadVal;
        armed  <= 1'b1;
        if (curMode == OP_TERM) outR <= 1'b0;
      end else if (cntTick && armed && !strb.stageLo) begin
        case (curMode)
          OP_RATE: begin
            if (count == CNT_W'(1)) begin
              count <= period;
              outR  <= 1'b1;
            end else begin
              count <= count - CNT_W'(1);
              outR  <= (count != CNT_W'(2));
            end
          end
          OP_SQUARE: begin
            if (count == CNT_W'(2)) begin
              count <= evenPeriod;
              outR  <= ~outR;
            end else begin
              count <= count - CNT_W'(2);
            end
          end
          default: begin
            count <= count - CNT_W'(1);
            if (count == CNT_W'(1)) outR <= 1'b1;
          end
        endcase
      end
    end
  end

  assign rdSrc   = strb.rdFromLatch ? latchVal : count;
  assign rdData  = strb.rdHigh ? rdSrc[CNT_W-1:BYTE_W] : rdSrc[BYTE_W-1:0];
  assign outLine = outR;

  AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == OP_TERM && outR && !strb.prog && !strb.commit) |=> outR); // R7
  AST_RATE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == OP_RATE && !outR && armed && cntTick && !strb.prog && !strb.commit
     && !strb.stageLo) |=> outR); // R8
  AST_SQ_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (armed && curMode == OP_SQUARE) |-> !count[0]); // R9
  AST_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !strb.commit) |=> $stable(count)); // R11

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CH_ID  = 0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              cntTick,
  output logic [BYTE_W-1:0] rdData,
  output logic              outLine
);

  ctrlStrobe_t strb;
  opMode_t     curMode;

  pit_ctrl #(.CH_ID(CH_ID), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataWr(dataWr), .dataRd(dataRd),
    .wrData(wrData), .strb(strb), .curMode(curMode)
  );

  pit_datapath #(.BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .curMode(curMode), .wrData(wrData),
    .cntTick(cntTick), .rdData(rdData), .outLine(outLine)
  );

endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;

  localparam int CLK_NS = 20;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       ctrlWr = 1'b0, dataWr = 1'b0, dataRd = 1'b0, cntTick = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       outLine;
  int         nTests = 0, nFails = 0;
  bit         done = 0;

  pit_channel #(.CH_ID(1), .BYTE_W(8)) uut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataWr(dataWr), .dataRd(dataRd),
    .wrData(wrData), .cntTick(cntTick), .rdData(rdData), .outLine(outLine)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic ctrl(input logic [7:0] b);
    wrData = b; ctrlWr = 1'b1;
    @(posedge clk); #1 ctrlWr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wrData = b; dataWr = 1'b1;
    @(posedge clk); #1 dataWr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    dataRd = 1'b1; #1 b = rdData;
    @(posedge clk); #1 dataRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    cntTick = 1'b1;
    repeat (n) @(posedge clk);
    #1 cntTick = 1'b0;
  endtask

  // Control words for channel 1: 0x40 | rw<<4 | mode<<1
  task automatic testReset();
    logic [7:0] b;
    chk1("R1 out after reset", outLine, 1'b0);
    rd(b); chk8("R1 low byte", b, 8'h00);
    rd(b); chk8("R1 high byte", b, 8'h00);
  endtask

  task automatic testMode0();
    ctrl(8'h70);
    wr(8'h05); wr(8'h00);
    chk1("R7 out low after load", outLine, 1'b0);
    ticks(4); chk1("R7 out low at count 1", outLine, 1'b0);
    ticks(1); chk1("R7 out high at zero", outLine, 1'b1);
    ticks(3); chk1("R7 out stays high", outLine, 1'b1);
  endtask

  task automatic testLatch();
    logic [7:0] b;
    ctrl(8'h70); wr(8'hE8); wr(8'h03);   // 1000
    ticks(10);                            // 990 = 0x03DE
    ctrl(8'h40);
    ticks(5);                             // 985 = 0x03D9
    ctrl(8'h40);                          // ignored, snapshot pending
    rd(b); chk8("R3 snapshot low", b, 8'hDE);
    rd(b); chk8("R4 snapshot high", b, 8'h03);
    rd(b); chk8("R4 live low after release", b, 8'hD9);
    rd(b); chk8("R5 live high", b, 8'h03);
  endtask

  task automatic testLoOnly();
    logic [7:0] b;
    ctrl(8'h50); wr(8'h20);
    ticks(2);                             // 0x1E
    ctrl(8'h40);
    ticks(3);                             // 0x1B
    rd(b); chk8("R4 one-byte snapshot", b, 8'h1E);
    rd(b); chk8("R6 low-only live read", b, 8'h1B);
  endtask

  task automatic testHiOnly();
    logic [7:0] b;
    ctrl(8'h60); wr(8'h01);               // 256
    rd(b); chk8("R6 high-only read", b, 8'h01);
    ticks(255); chk1("R6 out low at count 1", outLine, 1'b0);
    ticks(1);   chk1("R6 out high after 256", outLine, 1'b1);
  endtask

  task automatic testRate();
    logic [7:0] b;
    ctrl(8'h74);
    chk1("R8 out high after program", outLine, 1'b1);
    wr(8'h04); wr(8'h00);
    ticks(2); chk1("R8 high at count 2", outLine, 1'b1);
    ticks(1); chk1("R8 low at count 1", outLine, 1'b0);
    ticks(1); chk1("R8 high after reload", outLine, 1'b1);
    ctrl(8'h40);
    rd(b); chk8("R8 reloaded count low", b, 8'h04);
    rd(b); chk8("R8 reloaded count high", b, 8'h00);
    ticks(3); chk1("R8 second pulse", outLine, 1'b0);
  endtask

  task automatic testSquare();
    ctrl(8'h76);
    chk1("R9 out high after program", outLine, 1'b1);
    wr(8'h06); wr(8'h00);
    ticks(2); chk1("R9 high before half", outLine, 1'b1);
    ticks(1); chk1("R9 toggles low at half", outLine, 1'b0);
    ticks(3); chk1("R9 toggles high", outLine, 1'b1);
    ctrl(8'h76); wr(8'h07); wr(8'h00);    // odd period treated as 6
    ticks(2); chk1("R9 odd high before half", outLine, 1'b1);
    ticks(1); chk1("R9 odd toggles at 3", outLine, 1'b0);
  endtask

  task automatic testIgnored();
    logic [7:0] b;
    ctrl(8'h74); wr(8'h09); wr(8'h00);
    ctrl(8'h30);                          // channel 0, mode 0
    chk1("R2 other channel ignored", outLine, 1'b1);
    ctrl(8'hF0);                          // address 3
    chk1("R2 address 3 ignored", outLine, 1'b1);
    ctrl(8'h00);                          // latch for channel 0
    ticks(2);                             // 7
    rd(b); chk8("R2 foreign latch ignored", b, 8'h07);
  endtask

  task automatic testHalt();
    logic [7:0] b;
    ctrl(8'h70);
    ticks(4);
    wr(8'h10);
    ticks(3);                             // halted between bytes
    wr(8'h00);
    rd(b); chk8("R11 halted during load", b, 8'h10);
    rd(b); chk8("R11 high byte", b, 8'h00);
    wrData = 8'h00; dataWr = 1'b1; cntTick = 1'b0;
    @(posedge clk); #1 dataWr = 1'b0;     // low byte of next load
    wrData = 8'h02; dataWr = 1'b1; cntTick = 1'b1;
    @(posedge clk); #1 dataWr = 1'b0; cntTick = 1'b0;
    rd(b); chk8("R11 load beats tick", b, 8'h00);
    rd(b); chk8("R11 load beats tick high", b, 8'h02);
    wr(8'h33);                            // pointer now at high
    ctrl(8'h70);                          // pointers back to low
    wr(8'h44); wr(8'h00);
    rd(b); chk8("R5 pointer reset by program", b, 8'h44);
  endtask

  task automatic testAlias();
    ctrl(8'h7C);                          // mode 6
    chk1("R12 mode 6 out high", outLine, 1'b1);
    wr(8'h03); wr(8'h00);
    ticks(2); chk1("R12 mode 6 pulses low", outLine, 1'b0);
    ctrl(8'h73);                          // mode 1, BCD bit set
    chk1("R12 mode 1 out low", outLine, 1'b0);
    wr(8'h02); wr(8'h00);
    ticks(2); chk1("R12 mode 1 as mode 0, binary", outLine, 1'b1);
  endtask

  task automatic testZero();
    ctrl(8'h70); wr(8'h00); wr(8'h00);
    ticks(65535); chk1("R10 low after 65535", outLine, 1'b0);
    ticks(1);     chk1("R10 high after 65536", outLine, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testMode0();
    testLatch();
    testLoOnly();
    testHiOnly();
    testRate();
    testSquare();
    testIgnored();
    testHalt();
    testAlias();
    testZero();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule